// File: doc/BRIEF.md
# Packed SIMD Logical Right Shifter

This unit takes a 256-bit vector of packed elements and shifts every element right by one common amount. Zeros fill the vacated high bits. A lane-size code selects the element width: 16, 32 or 64 bits. The shift amount comes from one of two places. It can be a 64-bit count word or an 8-bit immediate.

Any amount larger than the last bit index of the element clears the whole shifted region. The amount does not wrap modulo the element width, and the comparison uses all 64 bits of the count.

A width code sets how many low bits receive shifted data: 64, 128 or 256. The bits above that active span are handled by a policy input. They either keep the previous destination value or are forced to zero.

For a two-operand form, where the destination is also the source, the caller drives the same vector on both the source and old-destination inputs. A three-operand form uses a separate source. The result and a valid flag are captured in one register stage.

Top module: `simd_srl_unit`

## Requirements
- R1: The lane-size code `laneSel` selects the element width: 2'b00 gives 16-bit lanes, 2'b01 gives 32-bit lanes and 2'b10 gives 64-bit lanes. Each lane of `srcVec` is shifted right independently, and the vacated high bits are filled with 0.
- R2: When the effective count is larger than 15 for 16-bit lanes, 31 for 32-bit lanes or 63 for 64-bit lanes, every active lane of the result is 0. Counts equal to those limits still shift normally.
- R3: The over-range test compares the full 64-bit unsigned count. Counts such as 2^32+1, or a count with only bit 63 set, clear the active lanes, even though their low bits alone would name a small shift.
- R4: When `useImm` is 1, the count is `immCount` zero-extended and applied to every lane, and `countWide` has no effect. When `useImm` is 0, `countWide` is the count.
- R5: The reserved lane code 2'b11 passes all 256 bits of `srcVec` to the result unchanged. In that case the count, the width code and `zeroUpper` have no effect.
- R6: The width code `widthSel` sets the active span: 2'b00 is bits 63:0, 2'b01 is bits 127:0, and 2'b10 or 2'b11 is all 256 bits. One count shifts every lane in the active span.
- R7: Bits above the active span come from `oldDest` when `zeroUpper` is 0, and are 0 when `zeroUpper` is 1.
- R8: When `inValid` is high at a rising clock edge, `result` takes the computed value and `outValid` is 1 after that edge. When `inValid` is low, `outValid` is 0 after the edge and `result` holds its previous value.
- R9: While `rstN` is low, `result` is 0 and `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands are valid this cycle |
| srcVec | input | 256 | Packed vector to be shifted |
| oldDest | input | 256 | Previous destination value, used for bits above the active span |
| countWide | input | 64 | 64-bit shift count |
| immCount | input | 8 | Immediate shift count |
| useImm | input | 1 | 1 selects the immediate count |
| laneSel | input | 2 | Lane size code: 00 16-bit, 01 32-bit, 10 64-bit, 11 pass-through |
| widthSel | input | 2 | Active span code: 00 64-bit, 01 128-bit, 10 or 11 256-bit |
| zeroUpper | input | 1 | 1 clears the bits above the active span, 0 keeps them from oldDest |
| outValid | output | 1 | Result register was loaded on the last edge |
| result | output | 256 | Registered shifted vector |

## Verification
A wrong shift amount or a wrong lane boundary in the control strobes appears in `result` on the edge right after the operation is issued. It typically shows as bits leaking across lane edges or as a shift that is off by the truncated count bits.

A faulty over-range flag shows up only at the limit counts: lane width minus one, lane width, and values whose nonzero bits all lie above bit 5. Those are the counts the bench drives.

A wrong block-activity mask shows in the upper 64-bit blocks of the same registered result. The error appears as zeros where old destination data was expected, or the reverse.

// File: rtl/srl_pkg.sv
package srl_pkg;
  parameter int VEC_W = 256;
  parameter int BLK_W = 64;
  parameter int CNT_W = 64;
  parameter int IMM_W = 8;
  localparam int NUM_BLK = VEC_W / BLK_W;
  localparam int SH_W = $clog2(BLK_W);

  typedef enum logic [1:0] {
    LANE16   = 2'b00,
    LANE32   = 2'b01,
    LANE64   = 2'b10,
    LANEPASS = 2'b11
  } laneKind_t;

  typedef struct packed {
    logic               passThru;
    laneKind_t          lane;
    logic               clearAll;
    logic [SH_W-1:0]    shAmt;
    logic [NUM_BLK-1:0] blkActive;
    logic               zeroUpper;
  } ctrlStrobes_t;
endpackage

// File: rtl/srl_ctrl.sv
module srl_ctrl
  import srl_pkg::*;
(
  input  logic [CNT_W-1:0] countWide,
  input  logic [IMM_W-1:0] immCount,
  input  logic             useImm,
  input  logic [1:0]       laneSel,
  input  logic [1:0]       widthSel,
  input  logic             zeroUpper,
  output ctrlStrobes_t     strobes
);
  logic [CNT_W-1:0] effCount;
  logic [CNT_W-1:0] laneMax;
  logic [3:0]       activeBlocks;
  laneKind_t        laneKind;

  assign laneKind = laneKind_t'(laneSel);
  assign effCount = useImm ? {{(CNT_W-IMM_W){1'b0}}, immCount} : countWide;

  always_comb begin
    unique case (laneKind)
      LANE16:  laneMax = CNT_W'(15);
      LANE32:  laneMax = CNT_W'(31);
      LANE64:  laneMax = CNT_W'(63);
      default: laneMax = {CNT_W{1'b1}};
    endcase
  end

  always_comb begin
    unique case (widthSel)
      2'b00:   activeBlocks = 4'd1;
      2'b01:   activeBlocks = 4'd2;
      default: activeBlocks = 4'd4;
    endcase
  end

  generate
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
      assign strobes.blkActive[b] = (4'(b) < activeBlocks);
    end
  endgenerate

  assign strobes.passThru  = (laneKind == LANEPASS);
  assign strobes.lane      = laneKind;
  assign strobes.clearAll  = (effCount > laneMax);
  assign strobes.shAmt     = effCount[SH_W-1:0];
  assign strobes.zeroUpper = zeroUpper;
endmodule

// File: rtl/srl_datapath.sv
module srl_datapath
  import srl_pkg::*;
(
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] oldDest,
  input  ctrlStrobes_t     strobes,
  output logic [VEC_W-1:0] shifted
);
  localparam int W16 = 16;
  localparam int W32 = 32;

  generate
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
      logic [BLK_W-1:0] srcBlk, oldBlk, sh16, sh32, sh64, picked;
      assign srcBlk = srcVec[b*BLK_W +: BLK_W];
      assign oldBlk = oldDest[b*BLK_W +: BLK_W];

      for (genvar w = 0; w < BLK_W / W16; w++) begin : g_w16
        assign sh16[w*W16 +: W16] = srcBlk[w*W16 +: W16] >> strobes.shAmt[3:0];
      end
      for (genvar d = 0; d < BLK_W / W32; d++) begin : g_w32
        assign sh32[d*W32 +: W32] = srcBlk[d*W32 +: W32] >> strobes.shAmt[4:0];
      end
      assign sh64 = srcBlk >> strobes.shAmt;

      always_comb begin
        unique case (strobes.lane)
          LANE16:  picked = sh16;
          LANE32:  picked = sh32;
          default: picked = sh64;
        endcase
        if (strobes.clearAll) picked = '0;
      end

      always_comb begin
        if (strobes.passThru)
          shifted[b*BLK_W +: BLK_W] = srcBlk;
        else if (strobes.blkActive[b])
          shifted[b*BLK_W +: BLK_W] = picked;
        else if (strobes.zeroUpper)
          shifted[b*BLK_W +: BLK_W] = '0;
        else
          shifted[b*BLK_W +: BLK_W] = oldBlk;
      end
    end
  endgenerate
endmodule

// File: rtl/simd_srl_unit.sv
module simd_srl_unit
  import srl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] oldDest,
  input  logic [CNT_W-1:0] countWide,
  input  logic [IMM_W-1:0] immCount,
  input  logic             useImm,
  input  logic [1:0]       laneSel,
  input  logic [1:0]       widthSel,
  input  logic             zeroUpper,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);
  ctrlStrobes_t     strobes;
  logic [VEC_W-1:0] shifted;

  srl_ctrl u_ctrl (
    .countWide(countWide), .immCount(immCount), .useImm(useImm),
    .laneSel(laneSel), .widthSel(widthSel), .zeroUpper(zeroUpper),
    .strobes(strobes)
  );

  srl_datapath u_dp (
    .srcVec(srcVec), .oldDest(oldDest), .strobes(strobes), .shifted(shifted)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) result <= shifted;
    end
  end

  // R8: valid tracks the issue strobe one edge later
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R8: idle cycles hold the result
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result)));
  // R2: 16-bit over-range count over full span clears everything
  assert_overrange_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneSel == 2'b00 && !useImm && countWide > 64'd15 && widthSel[1])
      |=> result == '0);
  // R5: reserved lane code passes the source
  assert_reserved_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneSel == 2'b11) |=> result == $past(srcVec));
  // R7: zero policy clears bits above a 64-bit span
  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneSel != 2'b11 && zeroUpper && widthSel == 2'b00)
      |=> result[VEC_W-1:BLK_W] == '0);
  // R7: merge policy keeps old bits above a 128-bit span
  assert_upper_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneSel != 2'b11 && !zeroUpper && widthSel == 2'b01)
      |=> result[VEC_W-1:2*BLK_W] == $past(oldDest[VEC_W-1:2*BLK_W]));
endmodule

// File: tb/simd_srl_unit_test.sv
`timescale 1ns/1ps
module simd_srl_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [255:0] srcVec = '0, oldDest = '0;
  logic [63:0] countWide = '0;
  logic [7:0] immCount = '0;
  logic useImm = 1'b0;
  logic [1:0] laneSel = '0, widthSel = '0;
  logic zeroUpper = 1'b0;
  logic outValid;
  logic [255:0] result;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  simd_srl_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcVec(srcVec), .oldDest(oldDest),
    .countWide(countWide), .immCount(immCount), .useImm(useImm), .laneSel(laneSel),
    .widthSel(widthSel), .zeroUpper(zeroUpper), .outValid(outValid), .result(result)
  );

  function automatic logic [255:0] refModel(
      input logic [255:0] s, input logic [255:0] o, input logic [63:0] c,
      input logic [7:0] im, input logic ui, input logic [1:0] ls,
      input logic [1:0] ws, input logic zu);
    logic [255:0] r;
    logic [63:0] cnt;
    int lw, span;
    if (ls == 2'b11) return s;
    cnt = ui ? {56'd0, im} : c;
    lw = (ls == 2'b00) ? 16 : (ls == 2'b01) ? 32 : 64;
    span = (ws == 2'b00) ? 64 : (ws == 2'b01) ? 128 : 256;
    r = '0;
    for (int l = 0; l < 256 / lw; l++) begin
      logic [63:0] e;
      e = '0;
      for (int k = 0; k < lw; k++) e[k] = s[l*lw + k];
      if (cnt >= 64'(lw)) e = '0;
      else e = e >> cnt[5:0];
      for (int k = 0; k < lw; k++) r[l*lw + k] = e[k];
    end
    for (int k = span; k < 256; k++) r[k] = zu ? 1'b0 : o[k];
    return r;
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic issue(input logic [255:0] s, input logic [255:0] o, input logic [63:0] c,
      input logic [7:0] im, input logic ui, input logic [1:0] ls,
      input logic [1:0] ws, input logic zu, input string tag);
    logic [255:0] exp;
    exp = refModel(s, o, c, im, ui, ls, ws, zu);
    @(negedge clk);
    srcVec = s; oldDest = o; countWide = c; immCount = im; useImm = ui;
    laneSel = ls; widthSel = ws; zeroUpper = zu; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(tag, result, exp);
    check({tag, " outValid R8"}, {255'd0, outValid}, 256'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R9 reset result", result, '0);
    check("R9 reset outValid", {255'd0, outValid}, '0);
  endtask

  task automatic t_lanes;
    logic [255:0] a;
    a = rnd256();
    issue(a, '0, 64'd3, 8'd0, 1'b0, 2'b00, 2'b10, 1'b0, "R1 word shift 3");
    issue(a, '0, 64'd0, 8'd0, 1'b0, 2'b00, 2'b10, 1'b0, "R1 word shift 0");
    issue(a, '0, 64'd17, 8'd0, 1'b0, 2'b01, 2'b10, 1'b0, "R1 dword shift 17");
    issue(a, '0, 64'd40, 8'd0, 1'b0, 2'b10, 2'b10, 1'b0, "R1 qword shift 40");
    issue({16{16'h8001}}, '0, 64'd1, 8'd0, 1'b0, 2'b00, 2'b10, 1'b0, "R1 no cross-lane leak");
  endtask

  task automatic t_limits;
    logic [255:0] a;
    a = rnd256() | {64{4'h8}};
    issue(a, '0, 64'd15, 8'd0, 1'b0, 2'b00, 2'b10, 1'b0, "R2 word count 15");
    issue(a, '0, 64'd16, 8'd0, 1'b0, 2'b00, 2'b10, 1'b0, "R2 word count 16");
    issue(a, '0, 64'd31, 8'd0, 1'b0, 2'b01, 2'b10, 1'b0, "R2 dword count 31");
    issue(a, '0, 64'd32, 8'd0, 1'b0, 2'b01, 2'b10, 1'b0, "R2 dword count 32");
    issue(a, '0, 64'd63, 8'd0, 1'b0, 2'b10, 2'b10, 1'b0, "R2 qword count 63");
    issue(a, '0, 64'd64, 8'd0, 1'b0, 2'b10, 2'b10, 1'b0, "R2 qword count 64");
  endtask

  task automatic t_wide;
    logic [255:0] a;
    a = rnd256() | {64{4'h1}};
    issue(a, '0, 64'h0000_0001_0000_0001, 8'd0, 1'b0, 2'b00, 2'b10, 1'b0, "R3 count 2^32+1");
    issue(a, '0, 64'h8000_0000_0000_0000, 8'd0, 1'b0, 2'b10, 2'b10, 1'b0, "R3 count bit63");
    issue(a, '0, 64'h0000_0000_0000_0040, 8'd0, 1'b0, 2'b01, 2'b10, 1'b0, "R3 count low bits zero");
  endtask

  task automatic t_imm;
    logic [255:0] a;
    a = rnd256();
    issue(a, '0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd5, 1'b1, 2'b00, 2'b10, 1'b0, "R4 imm 5 wide ignored");
    issue(a, '0, 64'd2, 8'd200, 1'b1, 2'b10, 2'b10, 1'b0, "R4 imm 200 over-range");
    issue(a, '0, 64'd2, 8'd200, 1'b0, 2'b01, 2'b10, 1'b0, "R4 wide used imm ignored");
  endtask

  task automatic t_reserved;
    logic [255:0] a, o;
    a = rnd256(); o = rnd256();
    issue(a, o, 64'd99, 8'd0, 1'b0, 2'b11, 2'b00, 1'b1, "R5 reserved pass");
  endtask

  task automatic t_widths;
    logic [255:0] a, o;
    a = rnd256(); o = rnd256();
    issue(a, o, 64'd4, 8'd0, 1'b0, 2'b00, 2'b00, 1'b0, "R6 R7 span64 keep");
    issue(a, o, 64'd4, 8'd0, 1'b0, 2'b00, 2'b00, 1'b1, "R6 R7 span64 zero");
    issue(a, o, 64'd9, 8'd0, 1'b0, 2'b01, 2'b01, 1'b0, "R6 R7 span128 keep");
    issue(a, o, 64'd9, 8'd0, 1'b0, 2'b01, 2'b01, 1'b1, "R6 R7 span128 zero");
    issue(a, o, 64'd7, 8'd0, 1'b0, 2'b10, 2'b11, 1'b1, "R6 span code 11 full");
    issue(a, o, 64'd70, 8'd0, 1'b0, 2'b10, 2'b00, 1'b0, "R2 R7 over-range span64 keep");
  endtask

  task automatic t_hold;
    logic [255:0] prev;
    issue(rnd256(), '0, 64'd1, 8'd0, 1'b0, 2'b00, 2'b10, 1'b0, "R8 setup");
    prev = result;
    @(negedge clk);
    srcVec = rnd256(); countWide = 64'd2; inValid = 1'b0;
    @(negedge clk);
    check("R8 idle hold result", result, prev);
    check("R8 idle outValid", {255'd0, outValid}, '0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rstN = 1'b1;
    t_lanes;
    t_limits;
    t_wide;
    t_imm;
    t_reserved;
    t_widths;
    t_hold;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule